// File: doc/BRIEF.md
# Fall-Through Shift-Strobe FIFO

This block is a first-in first-out buffer of 64 words by 9 bits in which every stored word drops toward the output end by itself. It has no read or write pointers. A word enters a head slot, and on each clock it moves one slot toward the tail whenever the slot ahead of it is empty. The tail slot is the output stage, and its contents are shown on the data output.

Two level strobes control traffic: a shift-in strobe and a shift-out strobe. Each strobe passes through a two-flop synchronizer and acts on both of its edges. A rising shift-in edge captures the input word, and the falling edge releases it down the chain. A rising shift-out edge claims the output word, and the falling edge removes it.

An input-ready flag and an output-ready flag give the handshake. Each flag goes low while its strobe is busy. A strobe held high finishes its transfer by itself once space or data appears.

An active-low enable gates the output word. An active-low asynchronous master reset clears all control state and leaves the stored data registers as they are. A sticky error bit records any shift-in pulse whose word could not be captured.

Top module: `ft_fifo`

## Requirements
- R1: The buffer accepts 64 words without any removal and then refuses more. Words leave in the order they were written, and every bit is carried unchanged.
- R2: While rst_n is low, in_ready reads 1, out_ready reads 0 and overflow reads 0, and all stored words are discarded. The word shown on dout is not altered by reset.
- R3: A rising edge on shift_in while in_ready is high captures din into the head slot, and in_ready reads 0 from a few clocks later. The word stays in the head slot for as long as shift_in remains high.
- R4: After shift_in falls, in_ready returns to 1 once the head slot drains. It stays 0 when the buffer holds 64 words.
- R5: If shift_in rises while the buffer is full and then stays high, a later removal frees the head slot. in_ready then reads 1 for at least one clock, and the pending din word is captured and kept as the newest word.
- R6: If shift_in is high while rst_n is low, the din word is captured after reset is released, with no further edge needed.
- R7: A rising edge on shift_out while out_ready is high drives out_ready to 0. The falling edge removes that word, and the next stored word then moves into the output stage. dout does not change while out_ready stays high.
- R8: After the last stored word is removed, out_ready stays 0 and dout keeps showing the removed word.
- R9: If shift_out rises while the buffer is empty and stays high, the next word to reach the output raises out_ready for exactly one clock and is then removed. Any later word stays in the output stage with out_ready at 1 until shift_out falls and rises again.
- R10: With oe_n high, dout reads all zeros and dout_drive reads 0. With oe_n low, dout shows the output-stage word and dout_drive reads 1.
- R11: A shift_in pulse that falls before its word could be captured leaves the stored words unchanged. It sets overflow to 1, and overflow stays at 1 until rst_n is asserted.
- R12: Into an empty buffer, a word reaches the output and raises out_ready within 70 clocks of shift_in falling. It moves one slot per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_in | input | 1 | Shift-in strobe: the rising edge captures, the falling edge releases |
| shift_out | input | 1 | Shift-out strobe: the rising edge claims, the falling edge removes |
| oe_n | input | 1 | Output enable, active low |
| din | input | 9 | Input word |
| dout | output | 9 | Output-stage word, zero when disabled |
| dout_drive | output | 1 | High when dout is being driven |
| in_ready | output | 1 | Head slot empty and ready for a word |
| out_ready | output | 1 | Valid word present on dout |
| overflow | output | 1 | Sticky lost-word error |

## Verification
The hardest state to reach from the ports is a strobe held high across a change of occupancy. This means shift_in raised on a full buffer and kept up until a removal lets its word in, or shift_out raised on an empty buffer and kept up until a word falls through. The bench reaches both by filling or draining the buffer completely with handshaked transfers. It then raises the strobe and watches the ready flag on every clock, so that the one-clock windows are caught. Randomized push and pop traffic with random gaps, checked against a queue model, covers ordering across partial fills.

// File: rtl/ft_pkg.sv
package ft_pkg;

  // Decoded view of one synchronized strobe.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } strobe_ev_t;

endpackage

// File: rtl/ft_strobe_sync.sv
module ft_strobe_sync
  import ft_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  output strobe_ev_t ev
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], strobe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  always_comb begin
    ev.level = sh_q[STAGES-1];
    ev.rise  = sh_q[STAGES-1] & ~prev_q;
    ev.fall  = ~sh_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/ft_chain.sv
module ft_chain #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             hold_head,
  input  logic             pop_tail,
  output logic             head_vld,
  output logic             tail_vld,
  output logic [WIDTH-1:0] tail_data
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [LAST-1:0]  adv;
  logic [WIDTH-1:0] slot_q [DEPTH];

  // A word advances when the slot ahead is empty; the head may be held.
  assign adv[0] = vld_q[0] & ~vld_q[1] & ~hold_head;

  generate
    for (genvar i = 1; i < LAST; i++) begin : g_adv
      assign adv[i] = vld_q[i] & ~vld_q[i+1];
    end
  endgenerate

  always_comb begin
    vld_d[0] = load | (vld_q[0] & ~adv[0]);
    for (int i = 1; i < LAST; i++) begin
      vld_d[i] = (vld_q[i] & ~adv[i]) | adv[i-1];
    end
    vld_d[LAST] = (vld_q[LAST] & ~pop_tail) | adv[LAST-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Data slots carry no reset: reset only declares them invalid.
  always_ff @(posedge clk) begin
    if (load) slot_q[0] <= din;
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (adv[i-1]) slot_q[i] <= slot_q[i-1];
      end
    end
  endgenerate

  assign head_vld  = vld_q[0];
  assign tail_vld  = vld_q[LAST];
  assign tail_data = slot_q[LAST];

endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
  import ft_pkg::*;
#(
  parameter int WIDTH       = 9,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic             shift_out,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_drive,
  output logic             in_ready,
  output logic             out_ready,
  output logic             overflow
);

  strobe_ev_t si_ev, so_ev;
  logic si_rise, si_fall, so_rise;

  ft_strobe_sync #(.STAGES(SYNC_STAGES)) u_si_sync (
    .clk(clk), .rst_n(rst_n), .strobe(shift_in), .ev(si_ev)
  );

  ft_strobe_sync #(.STAGES(SYNC_STAGES)) u_so_sync (
    .clk(clk), .rst_n(rst_n), .strobe(shift_out), .ev(so_ev)
  );

  assign si_rise = si_ev.rise;
  assign si_fall = si_ev.fall;
  assign so_rise = so_ev.rise;

  logic si_hold_q, si_hold_d, si_pend_q, si_pend_d;
  logic so_arm_q, so_arm_d, so_wait_q, so_wait_d;
  logic ovf_q, ovf_d;
  logic load, pop, head_vld, tail_vld;
  logic [WIDTH-1:0] q_raw;

  ft_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din),
    .hold_head(si_hold_q), .pop_tail(pop),
    .head_vld(head_vld), .tail_vld(tail_vld), .tail_data(q_raw)
  );

  // Input side: capture on a rising edge, or later while the strobe stays high.
  always_comb begin
    load      = ~head_vld & ~si_ev.fall & (si_ev.rise | (si_pend_q & si_ev.level));
    si_hold_d = si_hold_q;
    si_pend_d = si_pend_q;
    ovf_d     = ovf_q | (si_ev.fall & si_pend_q);
    if (si_ev.fall) begin
      si_hold_d = 1'b0;
      si_pend_d = 1'b0;
    end else if (load) begin
      si_hold_d = 1'b1;
      si_pend_d = 1'b0;
    end else if (si_ev.rise) begin
      si_pend_d = 1'b1;
    end
  end

  // Output side: claim on the rising edge, remove on the falling edge,
  // or remove automatically when the strobe was raised on an empty buffer.
  always_comb begin
    pop       = (so_ev.fall & so_arm_q) | (so_wait_q & tail_vld & so_ev.level);
    so_arm_d  = so_arm_q;
    so_wait_d = so_wait_q;
    if (so_ev.fall) begin
      so_arm_d  = 1'b0;
      so_wait_d = 1'b0;
    end else if (so_ev.rise) begin
      so_arm_d  = tail_vld;
      so_wait_d = ~tail_vld;
    end else if (so_wait_q & tail_vld) begin
      so_wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_hold_q <= 1'b0;
      si_pend_q <= 1'b0;
      so_arm_q  <= 1'b0;
      so_wait_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      si_hold_q <= si_hold_d;
      si_pend_q <= si_pend_d;
      so_arm_q  <= so_arm_d;
      so_wait_q <= so_wait_d;
      ovf_q     <= ovf_d;
    end
  end

  assign in_ready   = ~head_vld;
  assign out_ready  = tail_vld & ~so_arm_q;
  assign overflow   = ovf_q;
  assign dout_drive = ~oe_n;
  assign dout       = oe_n ? '0 : q_raw;

endmodule

// File: rtl/ft_fifo_chk.sv
module ft_fifo_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_ready,
  input logic             overflow,
  input logic             si_rise,
  input logic             si_fall,
  input logic             so_rise,
  input logic [WIDTH-1:0] q_raw
);

  // R3
  dir_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si_rise && in_ready) |=> !in_ready);

  // R7
  dor_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_rise && out_ready) |=> !out_ready);

  // R7
  q_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && $past(out_ready)) |-> $stable(q_raw));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow);

  // R11
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(si_fall));

endmodule

bind ft_fifo ft_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_ready(out_ready),
  .overflow(overflow), .si_rise(si_rise), .si_fall(si_fall),
  .so_rise(so_rise), .q_raw(q_raw)
);

// File: tb/ft_fifo_bench.sv
`timescale 1ns/1ps
module ft_fifo_bench;

  localparam int W = 9;
  localparam int D = 64;

  logic clk = 1'b0;
  logic rst_n, shift_in, shift_out, oe_n;
  logic [W-1:0] din, dout;
  logic dout_drive, in_ready, out_ready, overflow;

  int total = 0;
  int bad = 0;
  logic [W-1:0] model [$];
  logic [W-1:0] last_out;

  always #4 clk = ~clk;

  ft_fifo u_ft_fifo (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .shift_out(shift_out),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_drive(dout_drive),
    .in_ready(in_ready), .out_ready(out_ready), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Wait for a flag level; returns cycles waited, or -1 on timeout.
  task automatic wait_flag(input bit want_in, output int cyc);
    cyc = -1;
    for (int i = 0; i < 300; i++) begin
      if ((want_in ? in_ready : out_ready) == 1'b1) begin
        cyc = i;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic push(input logic [W-1:0] w);
    int c;
    wait_flag(1'b1, c);
    check(c >= 0, "R4 in_ready returns", c, 0);
    din = w;
    shift_in = 1'b1;
    tick(4);
    check(in_ready == 1'b0, "R3 busy after rise", in_ready, 0);
    shift_in = 1'b0;
    model.push_back(w);
    tick(2);
  endtask

  task automatic pop();
    int c;
    logic [W-1:0] exp;
    wait_flag(1'b0, c);
    check(c >= 0, "R7 out_ready rises", c, 0);
    exp = model.pop_front();
    check(dout == exp, "R1 order and data", dout, exp);
    shift_out = 1'b1;
    tick(4);
    check(out_ready == 1'b0, "R7 drop on rise", out_ready, 0);
    check(dout == exp, "R7 word steady while claimed", dout, exp);
    shift_out = 1'b0;
    last_out = exp;
    tick(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    model.delete();
    tick(2);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int c, highs;
    logic [W-1:0] wx;
    void'($urandom(32'd715));
    rst_n = 1'b0; shift_in = 1'b0; shift_out = 1'b0; oe_n = 1'b0; din = '0;
    tick(3);
    // R2 reset state
    check(in_ready == 1'b1, "R2 in_ready in reset", in_ready, 1);
    check(out_ready == 1'b0, "R2 out_ready in reset", out_ready, 0);
    check(overflow == 1'b0, "R2 overflow in reset", overflow, 0);
    rst_n = 1'b1;
    tick(2);

    // R12 fall-through latency into an empty buffer
    din = 9'h1A5; shift_in = 1'b1; tick(4); shift_in = 1'b0;
    model.push_back(9'h1A5);
    c = -1;
    for (int i = 0; i < 75; i++) begin
      if (out_ready) begin c = i; break; end
      @(negedge clk);
    end
    check(c >= 0 && c <= 70, "R12 latency", c, 70);
    check(dout == 9'h1A5, "R12 word at output", dout, 9'h1A5);

    // R10 output enable
    oe_n = 1'b1; tick(1);
    check(dout == '0, "R10 disabled dout", dout, 0);
    check(dout_drive == 1'b0, "R10 disabled drive", dout_drive, 0);
    oe_n = 1'b0; tick(1);
    check(dout == 9'h1A5 && dout_drive, "R10 enabled dout", dout, 9'h1A5);

    // R2 reset keeps the shown word, discards contents
    push(9'h0F0);
    tick(80);
    rst_n = 1'b0; tick(2);
    check(in_ready == 1'b1 && out_ready == 1'b0, "R2 flags after fill", {in_ready, out_ready}, 2);
    check(dout == 9'h1A5, "R2 dout kept", dout, 9'h1A5);
    rst_n = 1'b1; model.delete(); tick(80);
    check(out_ready == 1'b0, "R2 contents discarded", out_ready, 0);

    // R1 / R4 fill to capacity
    for (int i = 0; i < D; i++) push(W'(i * 7 + 3));
    tick(100);
    check(in_ready == 1'b0, "R4 full keeps in_ready low", in_ready, 0);

    // R5 held shift_in on a full buffer
    wx = 9'h155;
    din = wx; shift_in = 1'b1; tick(6);
    check(in_ready == 1'b0, "R5 pending while full", in_ready, 0);
    pop();
    highs = 0;
    for (int i = 0; i < 120; i++) begin
      if (in_ready) highs++;
      @(negedge clk);
    end
    check(highs >= 1, "R5 in_ready pulse", highs, 1);
    check(in_ready == 1'b0, "R5 pending word captured", in_ready, 0);
    shift_in = 1'b0; model.push_back(wx); tick(3);
    check(overflow == 1'b0, "R11 no error on held accept", overflow, 0);
    while (model.size() > 0) pop();
    // R8 empty after the last removal
    tick(100);
    check(out_ready == 1'b0, "R8 stays low when empty", out_ready, 0);
    check(dout == wx, "R8 last word shown", dout, wx);

    // R11 overflow on a full buffer
    for (int i = 0; i < D; i++) push(W'(9'h100 ^ i));
    tick(100);
    din = 9'h0AA; shift_in = 1'b1; tick(5); shift_in = 1'b0; tick(4);
    check(overflow == 1'b1, "R11 overflow set", overflow, 1);
    while (model.size() > 0) pop();
    tick(100);
    check(out_ready == 1'b0, "R11 lost word not stored", out_ready, 0);
    check(overflow == 1'b1, "R11 overflow sticky", overflow, 1);
    do_reset();
    check(overflow == 1'b0, "R11 cleared by reset", overflow, 0);

    // R9 shift_out held high on an empty buffer
    shift_out = 1'b1; tick(4);
    din = 9'h0C3; shift_in = 1'b1; tick(4); shift_in = 1'b0;
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      if (out_ready) highs++;
      @(negedge clk);
    end
    check(highs == 1, "R9 single-clock pulse", highs, 1);
    check(dout == 9'h0C3, "R9 auto-removed word shown", dout, 9'h0C3);
    push(9'h03C);
    tick(100);
    check(out_ready == 1'b1 && dout == 9'h03C, "R9 next word waits", dout, 9'h03C);
    shift_out = 1'b0; tick(3);
    pop();

    // R6 shift_in high through reset
    rst_n = 1'b0; din = 9'h1E1; shift_in = 1'b1; tick(3);
    rst_n = 1'b1; model.delete(); tick(6);
    check(in_ready == 1'b0, "R6 captured on release", in_ready, 0);
    shift_in = 1'b0; model.push_back(9'h1E1);
    tick(80);
    check(out_ready == 1'b1 && dout == 9'h1E1, "R6 word arrives", dout, 9'h1E1);
    pop();

    // R1 random traffic against the queue model
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 2);
      if (op != 0 && model.size() < D) push(W'($urandom_range(0, 511)));
      else if (model.size() > 0) pop();
      tick($urandom_range(0, 5));
    end
    while (model.size() > 0) pop();
    finish_run();
  end

endmodule